// File: doc/BRIEF.md
# Prescaled Reloading Periodic Timer

This block makes a periodic tick and interrupt from a slow clock enable. The enable is first divided by a prescaler whose ratio is a power of two from 1 to 32, picked by a 3-bit code. Each prescaled tick decrements a 16-bit counter. When a tick arrives with the counter at zero, the counter reloads from a preset register. The same event raises a one-cycle output pulse that can feed a watchdog, and sets a sticky terminal-count flag that can be routed to an interrupt line.

Software reaches three registers over a plain synchronous bus. Writes take effect at the clock edge and reads are combinational. Word 0 holds the prescaler code. Word 1 holds the reload preset. Word 2 is the control/status register. Its bit positions are fixed, because software decodes them: bit 0 restart, bit 1 terminal count, bit 2 interrupt enable, bit 3 watchdog control, bit 4 freeze enable.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, word 0 reads 0, word 1 reads 0xFFFF, word 2 reads 0, and `irq`, `tick_out` and `wd_ctl` are low.
- R2: Prescaler code c in 0..5 makes one counter tick per 2^c asserted `lf_tick` cycles. Codes 6 and 7 divide by 1 and read back as written.
- R3: With `lf_tick` held high and code c, `tick_out` pulses for one cycle every (PRESET+1)*2^c clock cycles. The pulse appears in the cycle after the edge on which the counter was zero and a tick arrived. At that same edge the counter reloads from the preset.
- R4: A write of 0 to word 1 stores 1. Any other value is stored as written.
- R5: Terminal count (word 2 bit 1) is set by every underflow. It is cleared by writing 1 to bit 1, and writing 0 to bit 1 leaves it unchanged. If an underflow and a clear land on the same edge, the underflow wins.
- R6: `irq` is high exactly when terminal count and interrupt enable (word 2 bit 2) are both set.
- R7: Writing 1 to word 2 bit 0 reloads the counter from the preset and clears the prescaler. Bit 0 always reads 0.
- R8: While freeze enable (word 2 bit 4) and `freeze_in` are both high, the counter and prescaler hold. `freeze_in` alone has no effect.
- R9: Word 2 bit 3 is stored and drives `wd_ctl`. Bits above 4 of word 2 and bits above 2 of word 0 read 0, and word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_tick | input | 1 | Low-frequency clock enable |
| freeze_in | input | 1 | Debug freeze request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| tick_out | output | 1 | One-cycle pulse per underflow |
| wd_ctl | output | 1 | Watchdog control bit |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit code with a largest shift of 5. Because the preset is programmed through the bus, small values such as 1 and 3 bring reload and wrap within a few dozen cycles. The largest divisor and the reserved codes can then be measured as exact periods. A second phase pulses `lf_tick` on every third cycle, so that prescaler phase, restart during counting and freeze are compared cycle by cycle against a behavioural model.

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_tick,
  input  logic              freeze_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tick_out,
  output logic              wd_ctl
);
  localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] preset_q, cnt_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic tc_q, ie_q, wdl_q, frz_q;

  logic wr_sel, wr_pre, wr_ctl, restart, run, tick, uf;

  assign wr_sel  = bus_we && bus_addr == A_SEL;
  assign wr_pre  = bus_we && bus_addr == A_PRE;
  assign wr_ctl  = bus_we && bus_addr == A_CTL;
  assign restart = wr_ctl && bus_wdata[0];

  assign pre_lim = (int'(sel_q) > MAX_SEL) ? '0 : PRE_W'((32'd1 << sel_q) - 32'd1);
  assign run     = lf_tick && !(frz_q && freeze_in);
  assign tick    = run && pre_q >= pre_lim;
  assign uf      = tick && !restart && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '1;
    end else if (restart) begin
      pre_q <= '0;
      cnt_q <= preset_q;
    end else if (run) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= (cnt_q == '0) ? preset_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      preset_q <= '1;
      tc_q     <= 1'b0;
      ie_q     <= 1'b0;
      wdl_q    <= 1'b0;
      frz_q    <= 1'b0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= uf;
      if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_pre) preset_q <= (bus_wdata[CNT_W-1:0] == '0) ? CNT_W'(1) : bus_wdata[CNT_W-1:0];
      if (wr_ctl) begin
        ie_q  <= bus_wdata[2];
        wdl_q <= bus_wdata[3];
        frz_q <= bus_wdata[4];
      end
      if (uf) tc_q <= 1'b1;
      else if (wr_ctl && bus_wdata[1]) tc_q <= 1'b0;
    end
  end

  assign irq    = tc_q & ie_q;
  assign wd_ctl = wdl_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SEL:   bus_rdata[SEL_W-1:0] = sel_q;
      A_PRE:   bus_rdata[CNT_W-1:0] = preset_q;
      A_CTL:   bus_rdata[4:0] = {frz_q, wdl_q, ie_q, tc_q, 1'b0};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module prescaled_reload_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_out,
  input logic             irq,
  input logic             tc_q,
  input logic             ie_q,
  input logic             frz_q,
  input logic             freeze_in,
  input logic             restart,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] preset_q,
  input logic [PRE_W-1:0] pre_q
);
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out);
  // R5
  tc_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> tc_q);
  // R4
  preset_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_q != '0);
  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);
  // R7
  restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(preset_q) && pre_q == '0));
  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && freeze_in && !restart) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

bind prescaled_reload_timer prescaled_reload_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_out(tick_out), .irq(irq), .tc_q(tc_q), .ie_q(ie_q),
  .frz_q(frz_q), .freeze_in(freeze_in), .restart(restart), .cnt_q(cnt_q),
  .preset_q(preset_q), .pre_q(pre_q)
);

// File: tb/tb_prescaled_reload_timer.sv
module tb_prescaled_reload_timer;
  logic clk = 0, rst_n = 0, lf_tick = 0, freeze_in = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic irq, tick_out, wd_ctl;
  int total = 0, bad = 0, cyc = 0, lf_mode = 0;

  always #5 clk = ~clk;

  prescaled_reload_timer dut (.*);

  // behavioural reference
  int m_sel, m_pre, m_cnt, m_preset;
  bit m_tc, m_ie, m_wdl, m_frz, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= 0; m_pre <= 0; m_cnt <= 65535; m_preset <= 65535;
      m_tc <= 0; m_ie <= 0; m_wdl <= 0; m_frz <= 0; m_out <= 0;
    end else begin
      int div; bit adv, tk, rs, under, cw;
      div = (m_sel <= 5) ? (1 << m_sel) : 1;
      adv = lf_tick && !(m_frz && freeze_in);
      tk = adv && (m_pre + 1 >= div);
      cw = bus_we && bus_addr == 2;
      rs = cw && bus_wdata[0];
      under = tk && !rs && m_cnt == 0;
      if (rs) begin m_pre <= 0; m_cnt <= m_preset; end
      else if (adv) begin
        m_pre <= tk ? 0 : m_pre + 1;
        if (tk) m_cnt <= (m_cnt == 0) ? m_preset : m_cnt - 1;
      end
      m_out <= under;
      if (bus_we && bus_addr == 0) m_sel <= int'(bus_wdata[2:0]);
      if (bus_we && bus_addr == 1) m_preset <= (bus_wdata == 0) ? 1 : int'(bus_wdata);
      if (cw) begin m_ie <= bus_wdata[2]; m_wdl <= bus_wdata[3]; m_frz <= bus_wdata[4]; end
      if (under) m_tc <= 1;
      else if (cw && bus_wdata[1]) m_tc <= 0;
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      0: return 16'(m_sel);
      1: return 16'(m_preset);
      2: return {11'd0, m_frz, m_wdl, m_ie, m_tc, 1'b0};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #3;
    if (rst_n) begin
      chk("R3 tick_out vs model", 16'(tick_out), 16'(m_out));
      chk("R6 irq vs model", 16'(irq), 16'(m_tc & m_ie));
      chk("R9 wd_ctl vs model", 16'(wd_ctl), 16'(m_wdl));
      chk("R9 rdata vs model", bus_rdata, m_read(bus_addr));
    end
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) lf_tick <= (lf_mode == 0) ? 1'b1 : (cyc % 3 == 0);

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] mask, input logic [15:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata & mask, exp);
  endtask

  task automatic period(input int exp, input string tag);
    int n = 0;
    while (tick_out !== 1'b1) @(negedge clk);
    @(negedge clk);
    while (tick_out !== 1'b1 && n < 5000) begin n++; @(negedge clk); end
    chk(tag, 16'(n + 1), 16'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq after reset", 16'(irq), 0);
    chk("R1 tick_out after reset", 16'(tick_out), 0);
    rst_n = 1;
    rd(0, 16'hFFFF, 16'h0000, "R1 code reset");
    rd(1, 16'hFFFF, 16'hFFFF, "R1 preset reset");
    rd(2, 16'hFFFF, 16'h0000, "R1 ctrl reset");
    chk("R1 wd_ctl after reset", 16'(wd_ctl), 0);

    wr(1, 3); wr(0, 0); wr(2, 1);
    period(4, "R3 preset 3 div 1");
    wr(0, 2); wr(2, 1);
    period(16, "R2 code 2 div 4");
    wr(0, 6); wr(2, 1);
    period(4, "R2 reserved code 6 as div 1");
    rd(0, 16'hFFFF, 16'h0006, "R2 reserved code reads back");
    wr(0, 7);
    period(4, "R2 reserved code 7 as div 1");
    wr(1, 1); wr(0, 5); wr(2, 1);
    period(64, "R3 preset 1 div 32");

    wr(1, 0);
    rd(1, 16'hFFFF, 16'h0001, "R4 zero preset clamps to 1");
    wr(1, 200); wr(0, 0); wr(2, 16'h0003);
    rd(2, 16'h0002, 16'h0000, "R5 tc cleared by write 1");
    while (tick_out !== 1'b1) @(negedge clk);
    rd(2, 16'h0002, 16'h0002, "R5 tc set by underflow");
    wr(2, 16'h0000);
    rd(2, 16'h0002, 16'h0002, "R5 write 0 keeps tc");
    chk("R6 irq low with enable off", 16'(irq), 0);
    wr(2, 16'h0004);
    #1 chk("R6 irq high with tc and enable", 16'(irq), 1);
    wr(2, 16'h0006);
    #1 chk("R6 irq low after tc clear", 16'(irq), 0);
    wr(2, 16'h0005);
    rd(2, 16'h0005, 16'h0004, "R7 restart bit reads 0");

    wr(1, 3); wr(2, 16'h0011);
    freeze_in = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (tick_out) seen++; end
      chk("R8 no ticks while frozen", 16'(seen), 0);
      wr(2, 16'h0000);
      while (tick_out !== 1'b1) @(negedge clk);
      seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (tick_out) seen++; end
      chk("R8 freeze_in alone ignored", 16'(seen), 10);
    end
    freeze_in = 0;

    wr(2, 16'hFFE8);
    rd(2, 16'hFFFD, 16'h0008, "R9 reserved ctrl bits read 0");
    chk("R9 wd_ctl follows bit 3", 16'(wd_ctl), 1);
    wr(0, 16'hFFFB);
    rd(0, 16'hFFFF, 16'h0003, "R9 code upper bits read 0");
    rd(3, 16'hFFFF, 16'h0000, "R9 word 3 reads 0");

    lf_mode = 1;
    wr(1, 2); wr(0, 1); wr(2, 16'h0004);
    repeat (60) @(negedge clk);
    wr(2, 16'h0015);
    freeze_in = 1;
    repeat (20) @(negedge clk);
    freeze_in = 0;
    repeat (40) @(negedge clk);
    wr(2, 16'h0007);
    repeat (30) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule